// File: doc/BRIEF.md
# Interrupt Input Router and Pending Latch

This block takes one flat vector of interrupt wires and sorts every wire into either the shared bank or one processor's private bank. Inputs are sampled on each clock. For every interrupt the block holds the last accepted level, a trigger-mode bit (edge or level) and a latched pending bit. It raises a per-bank strobe in the cycle after any stored level changes, so that downstream prioritisation logic knows which bank to recompute.

The low part of the vector (indices 0 to NUM_IRQ-33) feeds the shared bank. Input i there is interrupt ID i+32. The upper part is cut into 32-wide groups, one per processor slot. Only local IDs 16 to 31 can be driven from a wire. A wire that decodes to a local ID below 16, or to a slot beyond the configured processor count, has no effect on any bank and sets a sticky error flag.

Top module: `irq_line_router`

## Requirements
- R1: Input index i, with i below NUM_IRQ-32, drives `spi_pend` bit i, which is interrupt ID i+32 of the shared bank.
- R2: Input index NUM_IRQ-32+32*p+k, with p below NUM_CPU and k from 16 to 31, drives `ppi_pend` bit 32*p+k. Bits 32*p+0 to 32*p+15 of `ppi_pend` are always 0.
- R3: When a wire's sampled value equals its stored level, no state changes and no strobe is raised for that wire.
- R4: When a sampled value differs from the stored level, the stored level takes the new value at that clock edge. In the following cycle the strobe of the affected bank only (`spi_upd`, or `ppi_upd` bit p) is 1 for one cycle.
- R5: A 0-to-1 change sets the pending bit only if the interrupt's trigger-mode bit is 1 (edge). In level mode nothing is latched.
- R6: A 1-to-0 change never clears a latched pending bit.
- R7: The pending output is the latched pending bit, ORed with the stored level when the trigger-mode bit is 0 (level).
- R8: A wire decoding to a local ID below 16, or to a processor slot of NUM_CPU or more, changes no bank state and no strobe. While it is 1 it sets `map_err`, which stays 1 until reset.
- R9: A 1 on a `clr_spi` or `clr_ppi` bit clears that pending bit at the next edge. A rising edge that latches in the same cycle wins over the clear.
- R10: Reset clears all stored levels, pending bits, trigger-mode bits, strobes and `map_err`, so every interrupt starts in level mode.
- R11: With `cfg_spi_we`, or `cfg_ppi_we` bit p, high, the bank's trigger-mode bits load from the matching edge vector at the clock edge. A 1 bit selects edge mode. Private bits 0 to 15 stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IRQ-32+32*CPU_SLOTS | Flat interrupt wire vector |
| cfg_spi_we | input | 1 | Load shared trigger-mode bits |
| cfg_spi_edge | input | NUM_IRQ-32 | Shared trigger-mode values (1 = edge) |
| cfg_ppi_we | input | NUM_CPU | Load one processor's trigger-mode bits |
| cfg_ppi_edge | input | 32*NUM_CPU | Private trigger-mode values (1 = edge) |
| clr_spi | input | NUM_IRQ-32 | Write-one-to-clear, shared pending |
| clr_ppi | input | 32*NUM_CPU | Write-one-to-clear, private pending |
| spi_pend | output | NUM_IRQ-32 | Effective shared pending |
| ppi_pend | output | 32*NUM_CPU | Effective private pending |
| spi_upd | output | 1 | Shared bank level-change strobe |
| ppi_upd | output | NUM_CPU | Per-processor level-change strobe |
| map_err | output | 1 | Sticky illegal-wire flag |

## Verification
The hardest case to reach is a clear and a fresh rising edge on the same edge-mode interrupt in one cycle. The interrupt first has to be switched to edge mode, latched, released and then raised again while its clear bit is held. The stimulus builds this in steps: a configuration write, a rising edge, a falling edge that must leave the latch set, a lone clear, and then the combined raise-and-clear. A reference model tracks stored levels, so every strobe expectation follows from real level changes rather than from the wire values.

// File: rtl/irq_line_router.sv
module irq_line_router #(
  parameter int NUM_IRQ   = 64,
  parameter int NUM_CPU   = 2,
  parameter int CPU_SLOTS = 3,
  localparam int NUM_SPI  = NUM_IRQ - 32,
  localparam int PPI_W    = 32 * NUM_CPU,
  localparam int IN_W     = NUM_SPI + 32 * CPU_SLOTS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [IN_W-1:0]    irq_in,
  input  logic               cfg_spi_we,
  input  logic [NUM_SPI-1:0] cfg_spi_edge,
  input  logic [NUM_CPU-1:0] cfg_ppi_we,
  input  logic [PPI_W-1:0]   cfg_ppi_edge,
  input  logic [NUM_SPI-1:0] clr_spi,
  input  logic [PPI_W-1:0]   clr_ppi,
  output logic [NUM_SPI-1:0] spi_pend,
  output logic [PPI_W-1:0]   ppi_pend,
  output logic               spi_upd,
  output logic [NUM_CPU-1:0] ppi_upd,
  output logic               map_err
);

  localparam logic [31:0] WIRE_OK = 32'hFFFF_0000;

  function automatic logic [IN_W-1:0] illegal_lines();
    logic [IN_W-1:0] m;
    m = '0;
    for (int i = NUM_SPI; i < IN_W; i++) begin
      if ((i - NUM_SPI) / 32 >= NUM_CPU || (i - NUM_SPI) % 32 < 16) m[i] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [IN_W-1:0] ILLEGAL = illegal_lines();

  logic [NUM_SPI-1:0] spi_in, lvl_s, edge_s, pend_s;

  assign spi_in   = irq_in[NUM_SPI-1:0];
  assign spi_pend = pend_s | (lvl_s & ~edge_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_s   <= '0;
      edge_s  <= '0;
      pend_s  <= '0;
      spi_upd <= 1'b0;
      map_err <= 1'b0;
    end else begin
      lvl_s   <= spi_in;
      pend_s  <= (pend_s & ~clr_spi) | (spi_in & ~lvl_s & edge_s);
      spi_upd <= |(spi_in ^ lvl_s);
      map_err <= map_err | (|(irq_in & ILLEGAL));
      if (cfg_spi_we) edge_s <= cfg_spi_edge;
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [31:0] in_p, lvl_p, edge_p, pend_p;

    assign in_p = irq_in[NUM_SPI + 32*c +: 32] & WIRE_OK;
    assign ppi_pend[32*c +: 32] = pend_p | (lvl_p & ~edge_p);

    always_ff @(posedge clk) begin
      if (rst) begin
        lvl_p      <= '0;
        edge_p     <= '0;
        pend_p     <= '0;
        ppi_upd[c] <= 1'b0;
      end else begin
        lvl_p      <= in_p;
        pend_p     <= (pend_p & ~clr_ppi[32*c +: 32]) | (in_p & ~lvl_p & edge_p);
        ppi_upd[c] <= |(in_p ^ lvl_p);
        if (cfg_ppi_we[c]) edge_p <= cfg_ppi_edge[32*c +: 32] & WIRE_OK;
      end
    end
  end

endmodule

module irq_line_router_chk #(
  parameter int NUM_SPI = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SPI-1:0] spi_in,
  input logic [NUM_SPI-1:0] lvl_s,
  input logic [NUM_SPI-1:0] edge_s,
  input logic [NUM_SPI-1:0] pend_s,
  input logic [NUM_SPI-1:0] clr_spi,
  input logic               spi_upd,
  input logic               map_err
);

  assert_upd_on_change_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (spi_upd == ($past(spi_in) != $past(lvl_s))));

  assert_quiet_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(spi_in == lvl_s)) |-> $stable(lvl_s));

  assert_latch_only_edge_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |->
      ((pend_s & ~$past(pend_s) & ~($past(spi_in) & ~$past(lvl_s) & $past(edge_s))) == '0));

  assert_drop_only_by_clear_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(pend_s) & ~pend_s & ~$past(clr_spi)) == '0));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(map_err)) |-> map_err);

endmodule

bind irq_line_router irq_line_router_chk #(.NUM_SPI(NUM_SPI)) u_chk (
  .clk(clk), .rst(rst), .spi_in(spi_in), .lvl_s(lvl_s), .edge_s(edge_s),
  .pend_s(pend_s), .clr_spi(clr_spi), .spi_upd(spi_upd), .map_err(map_err)
);

// File: tb/irq_line_router_tb.sv
`timescale 1ns/1ps
module irq_line_router_tb;

  localparam int NSPI = 32;
  localparam int NCPU = 2;
  localparam int PW   = 64;
  localparam int IW   = 128;
  localparam logic [63:0] OKK = {2{32'hFFFF_0000}};

  logic clk = 0, rst = 1;
  logic [IW-1:0] irq_in = '0;
  logic cfg_spi_we = 0;
  logic [NSPI-1:0] cfg_spi_edge = '0, clr_spi = '0, spi_pend;
  logic [NCPU-1:0] cfg_ppi_we = '0, ppi_upd;
  logic [PW-1:0] cfg_ppi_edge = '0, clr_ppi = '0, ppi_pend;
  logic spi_upd, map_err;

  always #2.5 clk = ~clk;

  irq_line_router u_dut (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .cfg_spi_we(cfg_spi_we), .cfg_spi_edge(cfg_spi_edge),
    .cfg_ppi_we(cfg_ppi_we), .cfg_ppi_edge(cfg_ppi_edge),
    .clr_spi(clr_spi), .clr_ppi(clr_ppi),
    .spi_pend(spi_pend), .ppi_pend(ppi_pend),
    .spi_upd(spi_upd), .ppi_upd(ppi_upd), .map_err(map_err)
  );

  typedef struct {
    logic [NSPI-1:0] spi;
    logic [PW-1:0]   ppi;
    logic            su;
    logic [NCPU-1:0] pu;
    logic            err;
    string           tag;
  } exp_t;

  exp_t q[$];
  int vecs = 0, bad = 0;
  bit done = 0;

  logic [NSPI-1:0] m_lvl_s = '0, m_edge_s = '0, m_pend_s = '0;
  logic [PW-1:0]   m_lvl_p = '0, m_edge_p = '0, m_pend_p = '0;
  logic            m_err = 0;

  task automatic chk(input logic [63:0] act, input logic [63:0] expv, input string what);
    vecs++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", what, act, expv);
    end
  endtask

  task automatic step(input logic [IW-1:0] in, input logic [NSPI-1:0] cs, input logic [PW-1:0] cp,
                      input logic sw, input logic [NSPI-1:0] se, input logic [NCPU-1:0] pw,
                      input logic [PW-1:0] pe, input string tag);
    exp_t e;
    logic [NSPI-1:0] in_s;
    logic [PW-1:0] in_p, diff_p;
    @(negedge clk);
    irq_in = in; clr_spi = cs; clr_ppi = cp;
    cfg_spi_we = sw; cfg_spi_edge = se; cfg_ppi_we = pw; cfg_ppi_edge = pe;
    in_s = in[NSPI-1:0];
    in_p = in[NSPI +: PW] & OKK;
    e.su = |(in_s ^ m_lvl_s);
    diff_p = in_p ^ m_lvl_p;
    for (int c = 0; c < NCPU; c++) e.pu[c] = |diff_p[32*c +: 32];
    m_pend_s = (m_pend_s & ~cs) | (in_s & ~m_lvl_s & m_edge_s);
    m_pend_p = (m_pend_p & ~cp) | (in_p & ~m_lvl_p & m_edge_p);
    m_lvl_s = in_s;
    m_lvl_p = in_p;
    if (sw) m_edge_s = se;
    for (int c = 0; c < NCPU; c++) if (pw[c]) m_edge_p[32*c +: 32] = pe[32*c +: 32] & OKK[32*c +: 32];
    m_err = m_err | (|in[IW-1:NSPI+PW]) | (|(in[NSPI +: PW] & ~OKK));
    e.spi = m_pend_s | (m_lvl_s & ~m_edge_s);
    e.ppi = m_pend_p | (m_lvl_p & ~m_edge_p);
    e.err = m_err;
    e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(64'(spi_pend), 64'(e.spi), {e.tag, " spi_pend"});
      chk(64'(ppi_pend), 64'(e.ppi), {e.tag, " ppi_pend"});
      chk(64'(spi_upd),  64'(e.su),  {e.tag, " spi_upd"});
      chk(64'(ppi_upd),  64'(e.pu),  {e.tag, " ppi_upd"});
      chk(64'(map_err),  64'(e.err), {e.tag, " map_err"});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    vecs++; bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [IW-1:0] v;
    irq_in = {IW{1'b1}};
    repeat (3) @(posedge clk);
    #1;
    chk(64'(spi_pend), 0, "R10 reset spi_pend");
    chk(64'(ppi_pend), 0, "R10 reset ppi_pend");
    chk(64'({spi_upd, ppi_upd, map_err}), 0, "R10 reset strobes/err");
    @(negedge clk);
    irq_in = '0;
    rst = 0;
    step('0, '0, '0, 0, '0, '0, '0, "R3 idle");
    v = '0; v[3] = 1;
    step(v, '0, '0, 0, '0, '0, '0, "R1 R4 R7 shared level rise");
    step(v, '0, '0, 0, '0, '0, '0, "R3 hold");
    step('0, '0, '0, 0, '0, '0, '0, "R5 R7 level fall no latch");
    v = '0; v[32+17] = 1;
    step(v, '0, '0, 0, '0, '0, '0, "R2 R7 private level cpu0");
    step('0, '0, '0, 0, '0, '0, '0, "R2 private level drop");
    step('0, '0, '0, 1, 32'h20, 2'b11, 64'h8000_0000_0010_FFFF, "R11 config edges");
    v = '0; v[5] = 1; v[32+20] = 1; v[64+31] = 1;
    step(v, '0, '0, 0, '0, '0, '0, "R2 R5 R11 edge rise");
    step('0, '0, '0, 0, '0, '0, '0, "R6 fall keeps pending");
    step('0, 32'h20, 64'h0000_0000_0010_0000, 0, '0, '0, '0, "R9 clear");
    v = '0; v[5] = 1;
    step(v, 32'h20, '0, 0, '0, '0, '0, "R9 rise beats clear");
    step(v, '0, '0, 1, '0, '0, '0, "R7 R11 back to level");
    v[32+4] = 1;
    step(v, '0, '0, 0, '0, '0, '0, "R8 low local id ignored");
    v[32+4] = 0; v[100] = 1;
    step(v, '0, '0, 0, '0, '0, '0, "R8 absent slot ignored");
    step('0, '0, 64'h8000_0000_0000_0000, 0, '0, '0, '0, "R8 R9 sticky err and clear");
    repeat (3) @(posedge clk);
    #2;
    finish_run();
  end

endmodule